// File: doc/BRIEF.md
# SDRAM Burst Read Data Sequencer

This block is the read-side data sequencer of an SDRAM device model. When a read command is sampled it captures the start column, burst length code and burst order. It then steps through the beats of the burst, one column per cycle. Each beat is delayed by the programmed CAS latency of two or three cycles. The beat is then presented as a column address, which addresses the memory array outside this block, together with a data bus and an output-enable. The data bus returns the array word while the output-enable is high and is zero otherwise. It is the value a tristate pad would drive.

A per-cycle mask input blanks the output-enable two cycles after it is sampled. The column still advances, so the masked word is skipped and not delayed. A new read replaces the running burst at once. Beats already in flight still leave the pipeline, so back-to-back reads from interleaved banks produce a gapless stream. Full-page bursts wrap through the whole column range until a terminate strobe is sampled. Output then stops at the same latency offset as a normal read.

Top module: `sdram_rd_seq`

## Requirements
- R1: After reset, `oe` is low, `col` is zero and `dq` is zero.
- R2: The first beat of a read sampled at edge E is visible after edge E+CL. CL is 2 when `cfg_cl` is 0 and 3 when `cfg_cl` is 1.
- R3: `cfg_bl` codes 0, 1, 2 and 3 select bursts of 1, 2, 4 and 8 beats. Any code with bit 2 set selects full page. The beats of a burst follow each other on consecutive cycles.
- R4: After the last beat of a fixed-length burst, `oe` returns low and `col` returns to zero.
- R5: With `cfg_ilv` low, beat k has column `(start & ~(BL-1)) | ((start + k) & (BL-1))`. The count wraps inside the aligned block.
- R6: With `cfg_ilv` high and a fixed length, beat k has column `(start & ~(BL-1)) | ((start ^ k) & (BL-1))`.
- R7: A full-page burst gives column `start + k` modulo 2^COL_W and runs until `term` is sampled. A term sampled at edge T removes every beat from edge T+CL on. A read sampled in the same cycle as term wins.
- R8: `dqm` high at edge M forces `oe` low after edge M+2. The column sequence is not changed.
- R9: A read sampled during a running burst starts the new burst at once. The old beats already in the latency pipeline still appear, so the two bursts join without an idle cycle.
- R10: `dq` equals `arr_data` while `oe` is high and is zero while `oe` is low.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_cmd | input | 1 | Read command strobe |
| rd_col | input | COL_W | Start column of the read |
| cfg_bl | input | 3 | Burst length code |
| cfg_ilv | input | 1 | 1 = interleaved order, 0 = sequential order |
| cfg_cl | input | 1 | 0 = CAS latency 2, 1 = CAS latency 3 |
| dqm | input | 1 | Output mask, acts two cycles late |
| term | input | 1 | Burst terminate / precharge strobe |
| arr_data | input | DATA_W | Word read from the array at `col` |
| col | output | COL_W | Column of the beat on the bus |
| oe | output | 1 | Output-enable of the data pads |
| dq | output | DATA_W | Data driven to the pads |

## Verification
The bench uses the defaults COL_W=8 and DATA_W=16. With an 8-bit column, a full-page burst started at 0xFE wraps past 0xFF to 0x00 within a few beats, so the wrap can be checked in a short run. Eight bits are also wide enough to show aligned-block wrapping for every fixed length, in both orders, at both latencies. A constant 0xA5A5 array word makes every blanked cycle visible on `dq`.

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq #(
  parameter int COL_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_cmd,
  input  logic [COL_W-1:0]  rd_col,
  input  logic [2:0]        cfg_bl,
  input  logic              cfg_ilv,
  input  logic              cfg_cl,
  input  logic              dqm,
  input  logic              term,
  input  logic [DATA_W-1:0] arr_data,
  output logic [COL_W-1:0]  col,
  output logic              oe,
  output logic [DATA_W-1:0] dq
);

  logic             act, ilv_q, fp_q;
  logic [COL_W-1:0] base, idx, msk;
  logic             s1_v, s2_v, m1, m2;
  logic [COL_W-1:0] s1_c, s2_c;

  wire [COL_W-1:0] new_msk = cfg_bl[2] ? {COL_W{1'b1}}
                                       : COL_W'((1 << cfg_bl[1:0]) - 1);
  wire [COL_W-1:0] off     = ilv_q ? (base ^ idx) : (base + idx);
  wire [COL_W-1:0] iss_c   = (base & ~msk) | (off & msk);
  wire             sel_v   = cfg_cl ? s2_v : s1_v;
  wire [COL_W-1:0] sel_c   = cfg_cl ? s2_c : s1_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act   <= 1'b0;
      ilv_q <= 1'b0;
      fp_q  <= 1'b0;
      base  <= '0;
      idx   <= '0;
      msk   <= '0;
    end else if (rd_cmd) begin
      act   <= 1'b1;
      base  <= rd_col;
      idx   <= '0;
      msk   <= new_msk;
      fp_q  <= cfg_bl[2];
      ilv_q <= cfg_ilv & ~cfg_bl[2];
    end else if (term) begin
      act <= 1'b0;
    end else if (act) begin
      idx <= idx + 1'b1;
      if (!fp_q && idx == msk) act <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
      s1_c <= '0;
      s2_c <= '0;
      m1   <= 1'b0;
      m2   <= 1'b0;
      oe   <= 1'b0;
      col  <= '0;
    end else begin
      s1_v <= act;
      s1_c <= iss_c;
      s2_v <= s1_v;
      s2_c <= s1_c;
      m1   <= dqm;
      m2   <= m1;
      oe   <= sel_v & ~m2;
      col  <= sel_v ? sel_c : '0;
    end
  end

  assign dq = oe ? arr_data : '0;

endmodule

// File: rtl/sdram_rd_seq_chk.sv
module sdram_rd_seq_chk #(
  parameter int COL_W  = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_cmd,
  input logic              cfg_cl,
  input logic              dqm,
  input logic              term,
  input logic [DATA_W-1:0] arr_data,
  input logic              oe,
  input logic [DATA_W-1:0] dq
);

  logic [2:0] cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (cnt != 3'd4) cnt <= cnt + 1'b1;
  end

  assert_dq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> dq == '0);

  assert_dq_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> dq == arr_data);

  assert_mask_late_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= 3'd3 && $past(dqm, 3)) |-> !oe);

  assert_first_beat_cl2_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= 3'd4 && !cfg_cl && $past(rd_cmd, 3) && !$past(dqm, 3)) |-> oe);

  assert_first_beat_cl3_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= 3'd4 && cfg_cl && $past(rd_cmd, 4) && !$past(dqm, 4)) |-> oe);

  assert_term_stop_cl2_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= 3'd4 && !cfg_cl && $past(term, 3) && !$past(rd_cmd, 3)) |-> !oe);

  assert_term_stop_cl3_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= 3'd4 && cfg_cl && $past(term, 4) && !$past(rd_cmd, 4)) |-> !oe);

endmodule

bind sdram_rd_seq sdram_rd_seq_chk #(.COL_W(COL_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .cfg_cl(cfg_cl), .dqm(dqm),
  .term(term), .arr_data(arr_data), .oe(oe), .dq(dq)
);

// File: tb/sdram_rd_seq_bench.sv
module sdram_rd_seq_bench;
  localparam int COL_W = 8;
  localparam int DATA_W = 16;
  localparam logic [DATA_W-1:0] WORD = 16'hA5A5;

  logic clk = 0, rst_n = 0, rd_cmd = 0, cfg_ilv = 0, cfg_cl = 0, dqm = 0, term = 0;
  logic [COL_W-1:0] rd_col = '0;
  logic [2:0] cfg_bl = '0;
  logic [DATA_W-1:0] arr_data = WORD;
  logic [COL_W-1:0] col;
  logic oe;
  logic [DATA_W-1:0] dq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sdram_rd_seq #(.COL_W(COL_W), .DATA_W(DATA_W)) u_sdram_rd_seq (
    .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .rd_col(rd_col), .cfg_bl(cfg_bl),
    .cfg_ilv(cfg_ilv), .cfg_cl(cfg_cl), .dqm(dqm), .term(term),
    .arr_data(arr_data), .col(col), .oe(oe), .dq(dq));

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic beat(string req, bit e_oe, logic [COL_W-1:0] e_col, bit col_any);
    chk(req, oe, e_oe);
    if (!col_any) chk(req, col, e_col);
    chk("R10", dq, e_oe ? WORD : 0);
  endtask

  function automatic logic [COL_W-1:0] ecol(logic [COL_W-1:0] s, int k, int code, bit ilv);
    int bl;
    logic [COL_W-1:0] m;
    if (code >= 4) return COL_W'(s + k);
    bl = 1 << code;
    m = COL_W'(bl - 1);
    return (s & ~m) | ((ilv ? (s ^ COL_W'(k)) : COL_W'(s + k)) & m);
  endfunction

  task automatic start(logic [COL_W-1:0] s, int code, bit ilv);
    rd_cmd = 1; rd_col = s; cfg_bl = 3'(code); cfg_ilv = ilv;
  endtask

  task automatic burst(string req, logic [COL_W-1:0] s, int code, bit ilv, bit cl);
    int lat = cl ? 3 : 2;
    int nb = (1 << code);
    cfg_cl = cl;
    start(s, code, ilv);
    for (int n = 1; n <= lat + nb + 2; n++) begin
      tick();
      rd_cmd = 0;
      if (n - lat - 1 >= 0 && n - lat - 1 < nb)
        beat(req, 1, ecol(s, n - lat - 1, code, ilv), 0);
      else
        beat(n <= lat ? "R2" : "R4", 0, '0, 0);
    end
  endtask

  task automatic t_reset();
    beat("R1", 0, '0, 0);
  endtask

  task automatic t_fullpage();
    cfg_cl = 1;
    start(8'hFE, 7, 1);
    for (int n = 1; n <= 12; n++) begin
      tick();
      rd_cmd = 0;
      if (n - 4 >= 0 && n - 4 < 5) beat("R7", 1, ecol(8'hFE, n - 4, 7, 0), 0);
      else beat("R7", 0, '0, 0);
      term = (n == 5);
    end
  endtask

  task automatic t_interrupt();
    logic [COL_W-1:0] exp_c;
    cfg_cl = 0;
    start(8'h20, 3, 0);
    for (int n = 1; n <= 10; n++) begin
      tick();
      rd_cmd = 0;
      if (n == 3 || n == 4) beat("R9", 1, ecol(8'h20, n - 3, 3, 0), 0);
      else if (n >= 5 && n <= 8) begin
        exp_c = ecol(8'h41, n - 5, 2, 1);
        beat("R9", 1, exp_c, 0);
      end else beat("R9", 0, '0, 0);
      if (n == 2) start(8'h41, 2, 1);
    end
  endtask

  task automatic t_mask();
    cfg_cl = 0;
    start(8'h10, 3, 0);
    for (int n = 1; n <= 12; n++) begin
      tick();
      rd_cmd = 0;
      dqm = 0;
      if (n >= 3 && n <= 10) beat("R8", n != 6, ecol(8'h10, n - 3, 3, 0), 0);
      else beat("R8", 0, '0, 0);
      if (n == 6) chk("R8", col, 8'h13);
      if (n == 3) dqm = 1;
    end
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    t_reset();
    rst_n = 1;
    tick(); tick();
    burst("R5", 8'h0E, 2, 0, 0);
    burst("R6", 8'h35, 3, 1, 1);
    burst("R3", 8'h07, 0, 0, 0);
    burst("R3", 8'h07, 1, 0, 1);
    burst("R5", 8'h7D, 3, 0, 1);
    t_fullpage();
    t_interrupt();
    t_mask();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule